// File: doc/BRIEF.md
# Dual-Clock FIFO with Even Non-Power-of-Two Depth

This block moves data words from a write clock domain to an unrelated, slower read clock domain through an internal register array. The number of entries it holds can be any even count, 688 for example. The count does not have to be a power of two. Each side keeps its own pointers. A pointer crosses into the other domain only in Gray form, through a chain of synchronizer flops.

The pointers are binary counters that run over a window of twice the depth. The window is centred in the power-of-two code space, so its lowest and highest values are bit complements of each other. Because of this, the Gray step from the top of the window back to the bottom flips only the most significant bit. Both flags are registered and come from plain equality tests on Gray codes, with no Gray-to-binary decode:

- The read side keeps pointers one and two entries ahead of its current pointer. These drive `empty` and `almost_empty`.
- The write side keeps a pointer that trails its current pointer by exactly the depth, plus the next value of that trailing pointer. These drive `full`.

Reading is show-ahead. While `empty` is low, `rd_data` already holds the oldest word, and raising `rd_en` consumes it at the next read clock edge. A word written at a write clock edge is stored if `full` was low before that edge.

Top module: `np2_async_fifo`

## Requirements
- R1: Words leave in the order they were accepted, across any number of pointer wraps. Each binary pointer always stays inside its window of 2*DEPTH values and steps from the window top to the window bottom.
- R2: Every Gray pointer that crosses between domains changes in at most one bit per clock of its own domain, and this includes the wrap step.
- R3: Consider a settled FIFO whose reader is idle. `full` stays low through the first DEPTH-1 accepted writes and is high right after the write clock edge that accepts the DEPTH-th word.
- R4: A write attempted while `full` is high stores nothing and moves no pointer. That word never reaches `rd_data`, and `full` stays high.
- R5: A read attempted while `empty` is high consumes nothing and moves no pointer, and `empty` stays high.
- R6: When the only remaining entry is read, `empty` is high right after that read clock edge. While `empty` is low, `rd_data` shows the oldest unread word.
- R7: In a settled FIFO, `almost_empty` is high exactly when at most one word is unread. It is updated at the same read edge as the read that changes the count.
- R8: The flags are safe. No write is accepted while DEPTH words are unread, and `empty` is never low with nothing unread. Neither flag releases without the other side's pointer having moved.
- R9: With two synchronizer stages, `empty` falls within 5 read clocks after a write into an empty FIFO. `full` falls within 5 write clocks after a read from a full FIFO.
- R10: After reset, `full` is low and both `empty` and `almost_empty` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock, unrelated to `wr_clk` |
| rst_n | input | 1 | Active-low reset; asserts at once, released separately in each domain |
| wr_en | input | 1 | Write request; stores `wr_data` when `full` is low |
| wr_data | input | WIDTH | Word to store |
| full | output | 1 | No free entry may be assumed (write domain) |
| rd_en | input | 1 | Read request; consumes the head word when `empty` is low |
| rd_data | output | WIDTH | Oldest unread word, valid while `empty` is low |
| empty | output | 1 | No unread word may be assumed (read domain) |
| almost_empty | output | 1 | At most one unread word (read domain) |

## Verification
The assertions take for granted that DEPTH is even and at least 2, and that each input is driven only in its own clock domain. Under those conditions a Gray code changes in one bit per source clock. The assertions also take for granted that the other side's pointer moves only forward, so the flags may lag but never run ahead of the true count. The stimulus changes write-side inputs only at write clock falling edges and read-side inputs only at read clock falling edges. It still asserts `wr_en` into a full FIFO and `rd_en` into an empty one on purpose, both in directed steps and in random traffic. Exact flag values are checked only after both synchronizer chains have had time to settle. Random bursts run long enough to wrap the pointers many times.

// File: rtl/np2_fifo_pkg.sv
package np2_fifo_pkg;

  // Pointer width needed for a count window of twice the depth.
  function automatic int np2_ptr_width(input int depth);
    return $clog2(2 * depth);
  endfunction

  // Lowest window value; the window is centred so its ends are complements.
  function automatic int np2_win_lo(input int depth);
    return (1 << (np2_ptr_width(depth) - 1)) - depth;
  endfunction

  function automatic int np2_win_hi(input int depth);
    return np2_win_lo(depth) + 2 * depth - 1;
  endfunction

endpackage

// File: rtl/np2_rst_sync.sv
module np2_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/np2_ptr_sync.sv
module np2_ptr_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/np2_wr_ctl.sv
module np2_wr_ctl #(
  parameter int DEPTH = 688,
  parameter int PW    = 11,
  parameter int AW    = 10,
  parameter int LO    = 336,
  parameter int HI    = 1711
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] rq_gray,
  output logic          full,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wg
);
  localparam logic [PW-1:0] LO_P  = PW'(LO);
  localparam logic [PW-1:0] HI_P  = PW'(HI);
  localparam logic [PW-1:0] DEP_P = PW'(DEPTH);
  localparam logic [PW-1:0] TR0_P = PW'(LO + DEPTH);
  localparam logic [PW-1:0] TR1_P = PW'(LO + DEPTH + 1);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] x);
    return (x == HI_P) ? LO_P : x + 1'b1;
  endfunction

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] x);
    return x ^ (x >> 1);
  endfunction

  logic [PW-1:0] wp_q, wp_n;     // current write pointer
  logic [PW-1:0] wt_q, wt_n;     // write pointer minus DEPTH
  logic [PW-1:0] wt1_q, wt1_n;   // trailing pointer plus one
  logic [PW-1:0] wg_q, wg_n;     // Gray of wp, crosses domains
  logic          full_q, full_n;
  logic          accept;
  logic [PW-1:0] offset;

  always_comb begin
    accept = wr_en && !full_q;
    wp_n   = step(wp_q);
    wt_n   = wt1_q;
    wt1_n  = step(wt1_q);
    wg_n   = to_gray(step(wp_q));
    full_n = (to_gray(wt_q) == rq_gray) ||
             (accept && (to_gray(wt1_q) == rq_gray));
    offset = wp_q - LO_P;
    waddr  = (offset >= DEP_P) ? AW'(offset - DEP_P) : AW'(offset);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= LO_P;
      wt_q  <= TR0_P;
      wt1_q <= TR1_P;
      wg_q  <= to_gray(LO_P);
    end else if (accept) begin
      wp_q  <= wp_n;
      wt_q  <= wt_n;
      wt1_q <= wt1_n;
      wg_q  <= wg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_n;
  end

  assign full = full_q;
  assign we   = accept;
  assign wg   = wg_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full_q) |=> $stable(wp_q)); // R4
  AST_WR_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wg_q ^ $past(wg_q)) <= 1); // R2
  AST_WR_PTR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_q >= LO_P) && (wp_q <= HI_P)); // R1
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && $stable(rq_gray)) |=> full_q); // R8
endmodule

// File: rtl/np2_rd_ctl.sv
module np2_rd_ctl #(
  parameter int DEPTH = 688,
  parameter int PW    = 11,
  parameter int AW    = 10,
  parameter int LO    = 336,
  parameter int HI    = 1711
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wq_gray,
  output logic          empty,
  output logic          almost_empty,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rg
);
  localparam logic [PW-1:0] LO_P  = PW'(LO);
  localparam logic [PW-1:0] HI_P  = PW'(HI);
  localparam logic [PW-1:0] DEP_P = PW'(DEPTH);
  localparam logic [PW-1:0] LO1_P = PW'(LO + 1);
  localparam logic [PW-1:0] LO2_P = PW'(LO + 2);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] x);
    return (x == HI_P) ? LO_P : x + 1'b1;
  endfunction

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] x);
    return x ^ (x >> 1);
  endfunction

  logic [PW-1:0] rp_q, rp_n;      // current read pointer (addresses memory)
  logic [PW-1:0] rp1_q, rp1_n;    // one ahead
  logic [PW-1:0] rp2_q, rp2_n;    // two ahead
  logic [PW-1:0] rg_q, rg_n;      // Gray of current, crosses domains
  logic [PW-1:0] rg1_q, rg1_n;    // Gray of one ahead
  logic          empty_q, empty_n;
  logic          aempty_q, aempty_n;
  logic          accept;
  logic [PW-1:0] offset;

  always_comb begin
    accept   = rd_en && !empty_q;
    rp2_n    = step(rp2_q);
    rp1_n    = rp2_q;
    rp_n     = rp1_q;
    rg1_n    = to_gray(rp2_q);
    rg_n     = to_gray(rp1_q);
    empty_n  = (rg_q == wq_gray) || (accept && (rg1_q == wq_gray));
    aempty_n = empty_n || (rg1_q == wq_gray) ||
               (accept && (to_gray(rp2_q) == wq_gray));
    offset   = rp_q - LO_P;
    raddr    = (offset >= DEP_P) ? AW'(offset - DEP_P) : AW'(offset);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= LO_P;
      rp1_q <= LO1_P;
      rp2_q <= LO2_P;
      rg_q  <= to_gray(LO_P);
      rg1_q <= to_gray(LO1_P);
    end else if (accept) begin
      rp_q  <= rp_n;
      rp1_q <= rp1_n;
      rp2_q <= rp2_n;
      rg_q  <= rg_n;
      rg1_q <= rg1_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
    end else begin
      empty_q  <= empty_n;
      aempty_q <= aempty_n;
    end
  end

  assign empty        = empty_q;
  assign almost_empty = aempty_q;
  assign rg           = rg_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty_q) |=> $stable(rp_q)); // R5
  AST_RD_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rg_q ^ $past(rg_q)) <= 1); // R2
  AST_RD_PTR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_q >= LO_P) && (rp_q <= HI_P)); // R1
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_q && $stable(wq_gray)) |=> empty_q); // R8
  AST_EMPTY_IMPLIES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q |-> almost_empty); // R7
endmodule

// File: rtl/np2_async_fifo.sv
module np2_async_fifo
  import np2_fifo_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int DEPTH       = 688,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             almost_empty
);
  localparam int PW = np2_ptr_width(DEPTH);
  localparam int LO = np2_win_lo(DEPTH);
  localparam int HI = np2_win_hi(DEPTH);
  localparam int AW = $clog2(DEPTH);
  localparam logic [PW-1:0] LO_P    = PW'(LO);
  localparam logic [PW-1:0] GRAY_LO = LO_P ^ (LO_P >> 1);

  logic          wr_rst_n, rd_rst_n;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wg, rg, wg_in_rd, rg_in_wr;
  logic [WIDTH-1:0] mem [DEPTH];

  np2_rst_sync u_wr_rst (.clk(wr_clk), .rst_n_in(rst_n), .rst_n_out(wr_rst_n));
  np2_rst_sync u_rd_rst (.clk(rd_clk), .rst_n_in(rst_n), .rst_n_out(rd_rst_n));

  np2_wr_ctl #(.DEPTH(DEPTH), .PW(PW), .AW(AW), .LO(LO), .HI(HI)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rq_gray(rg_in_wr),
    .full(full), .we(we), .waddr(waddr), .wg(wg)
  );

  np2_rd_ctl #(.DEPTH(DEPTH), .PW(PW), .AW(AW), .LO(LO), .HI(HI)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wq_gray(wg_in_rd),
    .empty(empty), .almost_empty(almost_empty), .raddr(raddr), .rg(rg)
  );

  np2_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(GRAY_LO)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wg), .q(wg_in_rd)
  );

  np2_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(GRAY_LO)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rg), .q(rg_in_wr)
  );

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wr_data;
  end

  assign rd_data = mem[raddr];
endmodule

// File: tb/np2_async_fifo_test.sv
module np2_async_fifo_test;
  localparam int W     = 8;
  localparam int D     = 10;
  localparam int LAT   = 5;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rst_n, wr_en, rd_en;
  logic [W-1:0] wr_data, rd_data;
  logic full, empty, almost_empty;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;
  bit wdone = 0;
  logic [W-1:0] q [$];

  always #10 wr_clk = ~wr_clk;              // 50 MHz write clock
  initial begin
    #3;
    forever #17 rd_clk = ~rd_clk;           // slower, unrelated read clock
  end

  np2_async_fifo #(.WIDTH(W), .DEPTH(D), .SYNC_STAGES(2)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic bit expect_aempty(input int n);
    return n <= 1;
  endfunction

  // One fill-to-full and drain cycle; repeated rounds walk the pointers across the wrap.
  task automatic fill_round(input int round);
    int n;
    for (int k = 0; k < D; k++) begin
      @(negedge wr_clk);
      chk(full == 1'b0, "R3", "full before depth reached", int'(full), 0);
      wr_en   = 1'b1;
      wr_data = W'(round * 37 + k + 1);
      q.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
    chk(full == 1'b1, "R3", "full after depth-th write", int'(full), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge wr_clk);
      chk(full == 1'b1, "R4", "full held during write attempts", int'(full), 1);
      wr_en   = 1'b1;
      wr_data = 8'hEE;
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
    chk(full == 1'b1, "R4", "full after ignored writes", int'(full), 1);
    repeat (6) @(negedge rd_clk);
    @(negedge rd_clk);
    chk(rd_data == q[0], "R1", "head word of full fifo", int'(rd_data), int'(q[0]));
    rd_en = 1'b1;
    void'(q.pop_front());
    @(negedge rd_clk);
    rd_en = 1'b0;
    n = 0;
    do begin
      @(negedge wr_clk);
      n++;
    end while (full && n < 20);
    chk(!full && n <= LAT, "R9", "write clocks until full releases", n, LAT);
    while (q.size() > 0) begin
      @(negedge rd_clk);
      chk(empty == 1'b0, "R6", "empty while words unread", int'(empty), 0);
      chk(almost_empty == expect_aempty(q.size()), "R7", "almost_empty level",
          int'(almost_empty), int'(expect_aempty(q.size())));
      chk(rd_data == q[0], "R1", "drain order", int'(rd_data), int'(q[0]));
      chk(rd_data != 8'hEE, "R4", "word written while full leaked", int'(rd_data), 0);
      rd_en = 1'b1;
      void'(q.pop_front());
    end
    @(negedge rd_clk);
    rd_en = 1'b0;
    chk(empty == 1'b1, "R6", "empty right after last read", int'(empty), 1);
    chk(almost_empty == 1'b1, "R7", "almost_empty when drained", int'(almost_empty), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge rd_clk);
      rd_en = 1'b1;
      chk(empty == 1'b1, "R5", "empty held during read attempts", int'(empty), 1);
    end
    @(negedge rd_clk);
    rd_en = 1'b0;
    chk(empty == 1'b1, "R5", "empty after ignored reads", int'(empty), 1);
    repeat (8) @(negedge wr_clk);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (4) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (6) @(negedge rd_clk);
    @(negedge wr_clk);
    chk(full == 1'b0, "R10", "full after reset", int'(full), 0);
    @(negedge rd_clk);
    chk(empty == 1'b1, "R10", "empty after reset", int'(empty), 1);
    chk(almost_empty == 1'b1, "R10", "almost_empty after reset", int'(almost_empty), 1);

    for (int r = 0; r < 3; r++) fill_round(r);

    // single word into an empty fifo
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = 8'h5A; q.push_back(wr_data);
    @(negedge wr_clk);
    wr_en = 1'b0;
    n = 0;
    do begin
      @(negedge rd_clk);
      n++;
    end while (empty && n < 20);
    chk(!empty && n <= LAT, "R9", "read clocks until empty releases", n, LAT);
    chk(rd_data == 8'h5A, "R6", "show-ahead word", int'(rd_data), 'h5A);
    chk(almost_empty == 1'b1, "R7", "almost_empty with one word", int'(almost_empty), 1);
    rd_en = 1'b1;
    void'(q.pop_front());
    @(negedge rd_clk);
    rd_en = 1'b0;
    chk(empty == 1'b1, "R6", "empty after single read", int'(empty), 1);

    // random traffic: many pointer wraps exercise the Gray wrap step (R2)
    fork
      begin
        for (int i = 0; i < 3000; i++) begin
          @(negedge wr_clk);
          if (((i / 400) % 2) == 0) wr_en = ($urandom % 4) != 0;
          else                      wr_en = ($urandom % 8) == 0;
          wr_data = W'($urandom);
          if (wr_en && !full) begin
            chk(q.size() < D, "R8", "write accepted with depth unread", q.size(), D - 1);
            q.push_back(wr_data);
          end
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        wdone = 1;
      end
      begin
        while (!(wdone && q.size() == 0)) begin
          @(negedge rd_clk);
          if (!empty) begin
            chk(q.size() > 0, "R8", "empty low with nothing unread", q.size(), 1);
            if (q.size() > 0)
              chk(rd_data == q[0], "R1", "random order", int'(rd_data), int'(q[0]));
          end
          rd_en = ($urandom % 3) != 0;
          if (rd_en && !empty && q.size() > 0) void'(q.pop_front());
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
      end
    join

    repeat (6) @(negedge rd_clk);
    chk(empty == 1'b1, "R6", "empty after random drain", int'(empty), 1);
    chk(almost_empty == 1'b1, "R7", "almost_empty after random drain", int'(almost_empty), 1);
    repeat (6) @(negedge wr_clk);
    chk(full == 1'b0, "R8", "full low after random drain", int'(full), 0);
    finish_run();
  end
endmodule